// File: doc/BRIEF.md
# Overlapping-Window Register File

This block is the integer register file of a processor core that hands procedure arguments from caller to callee through overlapping register windows. An instruction names one of 32 logical registers with a 5-bit selector. The block turns that selector into an index in a larger physical array, using a current window pointer held as a frame number. Two read ports are purely combinational. One write port commits on the clock edge.

A call strobe moves the pointer up one frame and a return strobe moves it back one frame. Each frame is 12 physical registers apart: 8 private locals plus 4 argument registers. Because of this spacing, the 4 outgoing-argument registers of one frame are the same storage as the 4 incoming-argument registers of the next frame. Sixteen shared registers sit at the bottom of the physical array and do not move with the pointer.

Three conditions are reported as single-cycle flags: a return at the bottom frame, a call from the top frame, and a write whose mapped index falls past the end of the array. A read that falls past the end returns zero and raises a combinational flag. Spilling frames to memory and trap handling are done elsewhere.

Top module: `wrf_top`

## Requirements
- R1: Logical selectors 0 to 15 are shared registers and map to physical indices 0 to 15 in every frame. A value written there in one frame is read back unchanged in any other frame.
- R2: A selector s of 16 or more maps to physical index 16 + 12·f + (s − 16), where f is the current frame. Selectors 16–19 are incoming arguments, 20–27 are locals and 28–31 are outgoing arguments. Locals of one frame are never touched by writes made in another frame.
- R3: Outgoing argument s (28–31) of frame f is the same storage as incoming argument s − 12 (16–19) of frame f + 1.
- R4: `call_i` alone increments `cwp_o` by one on the next edge, and `ret_i` alone decrements it by one. `cwp_o` never exceeds the last frame, which is (520 − 16)/12 − 1 = 41 by default.
- R5: After reset `cwp_o` is 0 and all three registered flags are 0.
- R6: `ret_i` alone while `cwp_o` is 0 leaves `cwp_o` at 0 and raises `unf_o` for exactly the one cycle after that edge.
- R7: `call_i` alone while `cwp_o` is the last frame leaves `cwp_o` unchanged and raises `ovf_o` for exactly the one cycle after that edge.
- R8: A write on the same edge as a call or a return is mapped with the frame in effect before that edge.
- R9: A read whose mapped index is at or beyond the array size returns 0 with its `rdN_oob` flag high in the same cycle. A write whose mapped index is at or beyond the array size changes no register and raises `wr_oob_o` for the one cycle after the edge. In the top frame, the outgoing arguments 28–31 are such out-of-range registers.
- R10: When `call_i` and `ret_i` are both high on the same edge, the frame does not change and neither `ovf_o` nor `unf_o` rises.
- R11: A write becomes visible on the read ports in the cycle right after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_sel | input | 5 | Logical register for read port 0 |
| rd0_data | output | DATA_W | Read port 0 data, 0 when out of range |
| rd0_oob | output | 1 | Read port 0 maps past the array |
| rd1_sel | input | 5 | Logical register for read port 1 |
| rd1_data | output | DATA_W | Read port 1 data, 0 when out of range |
| rd1_oob | output | 1 | Read port 1 maps past the array |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 5 | Logical register to write |
| wr_data | input | DATA_W | Write data |
| call_i | input | 1 | Advance one frame |
| ret_i | input | 1 | Retreat one frame |
| cwp_o | output | FR_W | Current frame number |
| ovf_o | output | 1 | Call refused at the top frame, one-cycle pulse |
| unf_o | output | 1 | Return refused at frame 0, one-cycle pulse |
| wr_oob_o | output | 1 | Write dropped as out of range, one-cycle pulse |

## Verification
The hardest condition to reach is the top frame. There, the incoming arguments and locals are still in range, but the outgoing arguments fall past the end of the array, and any further call is refused. With the default array size this takes 41 calls in a row, so the bench shrinks the array to 64 registers. That leaves 4 frames, and the top frame's outgoing arguments land on indices 64–67. The bench then climbs frame by frame, writing every windowed register and sweeping both read ports over all 32 selectors against an arithmetic model. On the way it hits the refused call, the dropped writes and the overlap between adjacent frames. It then unwinds to frame 0 and checks the refused return.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    // Registered event flags of the register file
    typedef struct packed {
        logic ovf;   // call refused at the top frame
        logic unf;   // return refused at frame 0
        logic woob;  // write dropped, index past the array
    } wrf_flags_t;

    localparam int WRF_NPORT = 3;  // two read mappers and one write mapper
    localparam int WRF_WR    = 2;  // mapper slot used by the write port

endpackage

// File: rtl/wrf_map.sv
// Logical selector to physical index for one port
module wrf_map #(
    parameter int NUM_GLB  = 16,
    parameter int STEP     = 12,
    parameter int NUM_PHYS = 520,
    parameter int FR_W     = 6,
    parameter int SEL_W    = 5,
    parameter int PIDX_W   = 10
) (
    input  logic [FR_W-1:0]   frame_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [PIDX_W-1:0] pidx_o,
    output logic              oob_o
);
    int idx;

    always_comb begin
        if (int'(sel_i) < NUM_GLB) begin
            idx = int'(sel_i);
        end else begin
            idx = NUM_GLB + int'(frame_i) * STEP + (int'(sel_i) - NUM_GLB);
        end
        pidx_o = PIDX_W'(idx);
        oob_o  = (idx >= NUM_PHYS);
    end
endmodule

// File: rtl/wrf_step.sv
// Next frame number and refusal flags for call / return strobes
module wrf_step #(
    parameter int FR_W    = 6,
    parameter int LAST_FR = 41
) (
    input  logic            call_i,
    input  logic            ret_i,
    input  logic [FR_W-1:0] frame_i,
    output logic [FR_W-1:0] frame_o,
    output logic            ovf_o,
    output logic            unf_o
);
    always_comb begin
        frame_o = frame_i;
        ovf_o   = 1'b0;
        unf_o   = 1'b0;
        if (call_i && !ret_i) begin
            if (int'(frame_i) == LAST_FR) begin
                ovf_o = 1'b1;
            end else begin
                frame_o = frame_i + FR_W'(1);
            end
        end else if (ret_i && !call_i) begin
            if (frame_i == '0) begin
                unf_o = 1'b1;
            end else begin
                frame_o = frame_i - FR_W'(1);
            end
        end
    end
endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
    parameter int DATA_W   = 32,
    parameter int NUM_PHYS = 520,
    parameter int NUM_GLB  = 16,
    parameter int NUM_IN   = 4,
    parameter int NUM_LOC  = 8,
    parameter int NUM_OUT  = 4,
    localparam int NUM_LOG = NUM_GLB + NUM_IN + NUM_LOC + NUM_OUT,
    localparam int SEL_W   = $clog2(NUM_LOG),
    localparam int STEP    = NUM_IN + NUM_LOC,
    localparam int NUM_FR  = (NUM_PHYS - NUM_GLB) / STEP,
    localparam int LAST_FR = NUM_FR - 1,
    localparam int FR_W    = $clog2(NUM_FR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd0_sel,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_oob,
    input  logic [SEL_W-1:0]  rd1_sel,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_oob,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_i,
    input  logic              ret_i,
    output logic [FR_W-1:0]   cwp_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic              wr_oob_o
);
    localparam int ADDR_W = $clog2(NUM_PHYS);
    localparam int PIDX_W = $clog2(NUM_GLB + NUM_FR * STEP + NUM_LOG);
    localparam int NPORT  = wrf_pkg::WRF_NPORT;
    localparam int WRP    = wrf_pkg::WRF_WR;

    typedef struct packed {
        logic [FR_W-1:0]     cwp;
        wrf_pkg::wrf_flags_t flg;
    } wrf_state_t;

    wrf_state_t st_d, st_q;

    logic [DATA_W-1:0] mem_q [NUM_PHYS];

    logic [SEL_W-1:0]  sel_arr  [NPORT];
    logic [PIDX_W-1:0] pidx_arr [NPORT];
    logic              oob_arr  [NPORT];

    logic [FR_W-1:0]   cwp_nx;
    logic              ovf_nx;
    logic              unf_nx;
    logic              wr_go_d;
    logic [ADDR_W-1:0] wr_addr_d;

    assign sel_arr[0]   = rd0_sel;
    assign sel_arr[1]   = rd1_sel;
    assign sel_arr[WRP] = wr_sel;

    // One mapper per port; all use the registered frame (pre-update)
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_map #(
            .NUM_GLB (NUM_GLB),
            .STEP    (STEP),
            .NUM_PHYS(NUM_PHYS),
            .FR_W    (FR_W),
            .SEL_W   (SEL_W),
            .PIDX_W  (PIDX_W)
        ) u_map (
            .frame_i(st_q.cwp),
            .sel_i  (sel_arr[p]),
            .pidx_o (pidx_arr[p]),
            .oob_o  (oob_arr[p])
        );
    end

    wrf_step #(
        .FR_W   (FR_W),
        .LAST_FR(LAST_FR)
    ) u_step (
        .call_i (call_i),
        .ret_i  (ret_i),
        .frame_i(st_q.cwp),
        .frame_o(cwp_nx),
        .ovf_o  (ovf_nx),
        .unf_o  (unf_nx)
    );

    // Next-state computation
    always_comb begin
        st_d          = st_q;
        st_d.cwp      = cwp_nx;
        st_d.flg.ovf  = ovf_nx;
        st_d.flg.unf  = unf_nx;
        st_d.flg.woob = wr_en && oob_arr[WRP];
        wr_go_d       = wr_en && !oob_arr[WRP];
        wr_addr_d     = pidx_arr[WRP][ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Storage has no reset; software defines contents before use
    always_ff @(posedge clk) begin
        if (wr_go_d) begin
            mem_q[wr_addr_d] <= wr_data;
        end
    end

    // Combinational reads, zero when mapped past the array
    always_comb begin
        rd0_data = oob_arr[0] ? '0 : mem_q[pidx_arr[0][ADDR_W-1:0]];
        rd1_data = oob_arr[1] ? '0 : mem_q[pidx_arr[1][ADDR_W-1:0]];
    end

    assign rd0_oob  = oob_arr[0];
    assign rd1_oob  = oob_arr[1];
    assign cwp_o    = st_q.cwp;
    assign ovf_o    = st_q.flg.ovf;
    assign unf_o    = st_q.flg.unf;
    assign wr_oob_o = st_q.flg.woob;

endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
    parameter int DATA_W  = 32,
    parameter int FR_W    = 6,
    parameter int LAST_FR = 41
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic              ret_i,
    input logic              wr_en,
    input logic [FR_W-1:0]   cwp_o,
    input logic              ovf_o,
    input logic              unf_o,
    input logic              wr_oob_o,
    input logic              rd0_oob,
    input logic [DATA_W-1:0] rd0_data,
    input logic              rd1_oob,
    input logic [DATA_W-1:0] rd1_data
);
    AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && int'(cwp_o) != LAST_FR) |=> (cwp_o == $past(cwp_o) + FR_W'(1)) && !ovf_o); // R4
    AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && cwp_o != '0) |=> (cwp_o == $past(cwp_o) - FR_W'(1)) && !unf_o); // R4
    AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cwp_o) <= LAST_FR); // R4
    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && cwp_o == '0) |=> unf_o && cwp_o == '0); // R6
    AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_o) |-> $past(ret_i)); // R6
    AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && int'(cwp_o) == LAST_FR) |=> ovf_o && $stable(cwp_o)); // R7
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp_o) && !ovf_o && !unf_o); // R10
    AST_RD0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_oob |-> rd0_data == '0); // R9
    AST_RD1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_oob |-> rd1_data == '0); // R9
    AST_WOOB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oob_o |-> $past(wr_en)); // R9
endmodule

bind wrf_top wrf_chk #(
    .DATA_W (DATA_W),
    .FR_W   (FR_W),
    .LAST_FR(LAST_FR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .wr_en   (wr_en),
    .cwp_o   (cwp_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o),
    .wr_oob_o(wr_oob_o),
    .rd0_oob (rd0_oob),
    .rd0_data(rd0_data),
    .rd1_oob (rd1_oob),
    .rd1_data(rd1_data)
);

// File: tb/tb_wrf_top.sv
module tb_wrf_top;
    localparam int NPHYS = 64;
    localparam int STEP  = 12;
    localparam int NFR   = (NPHYS - 16) / STEP;  // 4 frames
    localparam int LAST  = NFR - 1;
    localparam int FRW   = $clog2(NFR);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        rd0_oob, rd1_oob, wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic [FRW-1:0] cwp_o;
    logic        ovf_o, unf_o, wr_oob_o;

    int checks = 0;
    int errors = 0;
    int cur = 0;
    logic [31:0] mdl [NPHYS];

    always #10 clk = ~clk;  // 50 MHz

    wrf_top #(.NUM_PHYS(NPHYS)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_sel(rd0_sel), .rd0_data(rd0_data), .rd0_oob(rd0_oob),
        .rd1_sel(rd1_sel), .rd1_data(rd1_data), .rd1_oob(rd1_oob),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i), .cwp_o(cwp_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .wr_oob_o(wr_oob_o)
    );

    function automatic int pmap(int sel, int f);
        return (sel < 16) ? sel : 16 + f * STEP + (sel - 16);
    endfunction

    function automatic logic [31:0] tag(int f, int sel, int salt);
        return 32'hA500_0000 | (salt << 16) | (f << 8) | sel;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One clocked operation; flags and frame checked after its edge
    task automatic op(input bit c, input bit r, input bit w, input int sel, input logic [31:0] d, input string req);
        bit eo, eu, ew;
        int p, nf;
        @(negedge clk);
        call_i = c; ret_i = r; wr_en = w; wr_sel = 5'(sel); wr_data = d;
        p  = pmap(sel, cur);
        eo = c && !r && cur == LAST;
        eu = r && !c && cur == 0;
        ew = w && p >= NPHYS;
        nf = cur;
        if (c && !r && cur != LAST) nf = cur + 1;
        if (r && !c && cur != 0) nf = cur - 1;
        if (w && p < NPHYS) mdl[p] = d;
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0; wr_en = 1'b0;
        cur = nf;
        chk(int'(cwp_o) == cur, req, 32'(cwp_o), 32'(cur));
        chk(ovf_o == eo, {req, " ovf"}, 32'(ovf_o), 32'(eo));
        chk(unf_o == eu, {req, " unf"}, 32'(unf_o), 32'(eu));
        chk(wr_oob_o == ew, {req, " wr_oob"}, 32'(wr_oob_o), 32'(ew));
    endtask

    // Sweep both read ports over all 32 selectors against the model
    task automatic sweep(input string req);
        int p0, p1;
        logic [31:0] e0, e1;
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            rd0_sel = 5'(s);
            rd1_sel = 5'(31 - s);
            #1;
            p0 = pmap(s, cur);
            p1 = pmap(31 - s, cur);
            e0 = (p0 >= NPHYS) ? 32'h0 : mdl[p0];
            e1 = (p1 >= NPHYS) ? 32'h0 : mdl[p1];
            chk(rd0_data === e0, {req, " rd0"}, rd0_data, e0);
            chk(rd1_data === e1, {req, " rd1"}, rd1_data, e1);
            chk(rd0_oob == (p0 >= NPHYS), "R9 rd0_oob", 32'(rd0_oob), 32'(p0 >= NPHYS));
            chk(rd1_oob == (p1 >= NPHYS), "R9 rd1_oob", 32'(rd1_oob), 32'(p1 >= NPHYS));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state
        chk(cwp_o == '0, "R5 cwp", 32'(cwp_o), 0);
        chk(!ovf_o && !unf_o && !wr_oob_o, "R5 flags", {29'b0, ovf_o, unf_o, wr_oob_o}, 0);

        // R6: return at frame 0 refused, one-cycle pulse
        op(1'b0, 1'b1, 1'b0, 0, 0, "R6 underflow");
        @(negedge clk);
        chk(!unf_o, "R6 pulse ends", 32'(unf_o), 0);

        // Climb: frame 0 writes all, later frames write windowed only
        for (int f = 0; f < NFR; f++) begin
            if (f > 0) begin
                // R3: incoming args equal previous frame's outgoing tags
                for (int s = 16; s < 20; s++) begin
                    @(negedge clk);
                    rd0_sel = 5'(s);
                    #1;
                    chk(rd0_data === tag(f - 1, s + 12, 1), "R3 overlap", rd0_data, tag(f - 1, s + 12, 1));
                end
            end
            for (int s = (f == 0) ? 0 : 16; s < 32; s++)
                op(1'b0, 1'b0, 1'b1, s, tag(f, s, 1), "R9 R11 write");
            sweep("R1 R2 R11 climb");
            op(1'b1, 1'b0, 1'b0, 0, 0, (f == LAST) ? "R7 overflow" : "R4 call");
        end
        @(negedge clk);
        chk(!ovf_o, "R7 pulse ends", 32'(ovf_o), 0);

        // R10: call and return together hold
        op(1'b1, 1'b1, 1'b0, 0, 0, "R10 both at top");

        // Unwind: locals of each frame must survive (R2), globals (R1)
        for (int f = LAST; f > 0; f--) begin
            op(1'b0, 1'b1, 1'b0, 0, 0, "R4 return");
            sweep("R1 R2 unwind");
        end

        // R8: write with call uses old frame; write with return likewise
        op(1'b1, 1'b0, 1'b1, 20, 32'h1111_2222, "R8 write+call");
        sweep("R8 after call");
        op(1'b0, 1'b1, 1'b1, 28, 32'h3333_4444, "R8 write+ret");
        sweep("R8 after ret");
        op(1'b1, 1'b0, 1'b0, 0, 0, "R4 call");
        op(1'b1, 1'b0, 1'b0, 0, 0, "R4 call");
        sweep("R3 R8 arg landed");
        op(1'b1, 1'b1, 1'b1, 5, 32'h5555_6666, "R10 both mid + R1 write");
        sweep("R1 R10 sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule